// File: doc/BRIEF.md
# Frame Setup Sequencer for a Display Fetch Engine

This block prepares each frame for a display fetch engine. When the display is switched on, it checks that the bus fabric accepts the buffer boundary addresses. It then loads the colour-table header from the start of buffer 0, unless the header mode is data-only. On every frame start it reads the header again from the active buffer. It takes the pixel depth from a 3-bit code in header word 0 and works out where the pixel data begins. It checks that the whole frame fits inside the buffer, and it applies an optional subpanel override.

On success it hands the pixel fetcher a base address, a line stride, a line count and a first line. It also pulses a per-buffer DMA condition bit and, in double-buffer mode, switches to the other buffer. On failure it raises an error status and asks the register bank to clear the enable bit. The header words are passed out one by one so that an external colour table can store them. Pixel conversion happens downstream and is not part of this block.

Top module: `frame_setup_seq`

## Requirements
- R1: When the sequencer leaves the off state on `cfg_enable`, it needs `addr_ok[0]` and `addr_ok[1]` (buffer 0 top and bottom) high, and in double-buffer mode also `addr_ok[2]` and `addr_ok[3]` (buffer 1). If a needed flag is low, it pulses `cond_set[2]` and `enable_clr`, pulses `dma_irq` when `cfg_dma_ie[1]` is set, and issues no memory read. The buffer 1 flags are ignored in single-buffer mode.
- R2: After a clean enable check with `cfg_hdr_mode` not equal to 2, the block reads HDR_WORDS 16-bit words from the top of buffer 0 at byte addresses top, top+2, top+4 and so on. Each word appears on `pal_we`/`pal_idx`/`pal_wdata` in index order. `stat_pal_done` rises after the last word and is cleared by the next enable.
- R3: A `frame_start` pulse while the block is ready re-reads all the header words from the top of the current buffer before the frame is evaluated, unless `cfg_hdr_mode` is 2. In that mode no memory read is made.
- R4: Header word 0 bits 14:12 select the depth shown on `fetch_bpp`: code 1 gives 2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16. Code 0 gives one `frame_abort` pulse, with no fetch, no condition bit and no change of buffer.
- R5: `fetch_base` is the buffer top plus 0x200 for codes 3 to 7 and plus 0x20 for codes 1 and 2. In data-only mode (2) the offset is 0 and the code comes from the most recently read word 0, which is 0 after reset.
- R6: With W = `cfg_width_m1`+1 and H = `cfg_height_m1`+1, the frame needs offset + W*H*bpp/8 bytes. If that exceeds (bottom - top) + 2 of the active buffer, `stat_sync_err` is set, `enable_clr` pulses, and there is no fetch and no condition bit. Exact equality passes.
- R7: `fetch_stride` is W*bpp/8. Without an override, `fetch_lines` is H and `fetch_first` is 0.
- R8: With `cfg_sub_ovr` set, `cfg_sub_start` high makes `fetch_first` = `cfg_sub_val` (lines stay H). `cfg_sub_start` low makes `fetch_lines` = `cfg_sub_val` (first stays 0).
- R9: A successful frame pulses `fetch_valid` together with `cond_set` bit 0 (buffer 0) or bit 1 (buffer 1), and with `dma_irq` when `cfg_dma_ie[0]` is set. In double-buffer mode `cur_buf` toggles; otherwise it stays 0.
- R10: A falling `cfg_enable` makes `buf_idle` 1 and clears `stat_sync_err` on the next cycle. It sets `stat_frame_done` unless `cfg_hdr_mode` is 1. Enabling clears `stat_frame_done` and selects buffer 0.
- R11: `lcd_irq` = (`stat_frame_done` & `cfg_irq_mask[0]`) | (`stat_pal_done` & `cfg_irq_mask[1]`) | `stat_sync_err`.
- R12: After reset all pulse outputs, `mem_req` and the status bits are 0 and `buf_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Display enable level |
| cfg_hdr_mode | input | 2 | Header mode; 2 = data only, 1 = frame-done suppressed |
| cfg_dual | input | 1 | Double-buffer mode |
| cfg_width_m1 | input | LINE_W | Width minus one, in pixels |
| cfg_height_m1 | input | LINE_W | Height minus one, in lines |
| cfg_sub_ovr | input | 1 | Subpanel override active |
| cfg_sub_start | input | 1 | Override sets first line (1) or line count (0) |
| cfg_sub_val | input | LINE_W | Override value |
| cfg_irq_mask | input | 2 | Frame-done / header-done interrupt masks |
| cfg_dma_ie | input | 2 | DMA interrupt enables: [0] frame, [1] address error |
| buf0_top | input | ADDR_W | Buffer 0 start byte address |
| buf0_bot | input | ADDR_W | Buffer 0 end byte address |
| buf1_top | input | ADDR_W | Buffer 1 start byte address |
| buf1_bot | input | ADDR_W | Buffer 1 end byte address |
| addr_ok | input | 4 | Address valid flags: b0 top, b0 bottom, b1 top, b1 bottom |
| frame_start | input | 1 | Frame start pulse |
| mem_req | output | 1 | Header read request |
| mem_addr | output | ADDR_W | Header read byte address |
| mem_ack | input | 1 | Read accepted, data valid |
| mem_rdata | input | 16 | Header read data |
| pal_we | output | 1 | Header word strobe |
| pal_idx | output | $clog2(HDR_WORDS) | Header word index |
| pal_wdata | output | 16 | Header word |
| fetch_valid | output | 1 | Fetch parameters valid pulse |
| fetch_base | output | ADDR_W | Pixel data base address |
| fetch_stride | output | LINE_W+2 | Line stride in bytes |
| fetch_lines | output | LINE_W+1 | Lines to fetch |
| fetch_first | output | LINE_W | First line |
| fetch_bpp | output | 5 | Bits per pixel |
| frame_abort | output | 1 | Unsupported depth pulse |
| cond_set | output | 3 | DMA condition bit pulses |
| dma_irq | output | 1 | DMA interrupt pulse |
| enable_clr | output | 1 | Request to clear the enable bit |
| lcd_irq | output | 1 | Display interrupt level |
| stat_sync_err | output | 1 | Frame overrun status |
| stat_pal_done | output | 1 | Header loaded status |
| stat_frame_done | output | 1 | Display stopped status |
| cur_buf | output | 1 | Active buffer index |
| buf_idle | output | 1 | No active buffer (disabled) |

## Verification
A corrupted buffer index shows at once on the next `fetch_valid`: both `fetch_base` and the `cond_set` bit point at the wrong buffer. A wrong header-read counter or address appears at the ports within one word, as an out-of-order `pal_idx` or a `mem_addr` that breaks the 2-byte step. It also shows a header's worth of cycles later as a wrong depth or offset. A fit or status register that holds a stale value shows up on the first frame evaluation after it, through `stat_sync_err`, `enable_clr` or `lcd_irq`.

// File: rtl/frame_setup_pkg.sv
package frame_setup_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_CHK, ST_LOAD, ST_RDY, ST_HDR, ST_EVAL, ST_HALT
  } seq_st_t;

  localparam int unsigned SKIP_LONG  = 32'h200;
  localparam int unsigned SKIP_SHORT = 32'h20;
  localparam int unsigned FIT_SLACK  = 2;

  // depth code (header word 0 bits 14:12) to bits per pixel, 0 = unsupported
  function automatic logic [4:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd0;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [31:0] data_skip(input logic [2:0] code, input logic data_only);
    if (data_only)      return 32'd0;
    else if (code >= 3) return SKIP_LONG;
    else                return SKIP_SHORT;
  endfunction

  function automatic logic [31:0] line_stride(input logic [31:0] w, input logic [31:0] bpp);
    return (w * bpp) >> 3;
  endfunction

  function automatic logic [31:0] frame_bytes(input logic [31:0] w, input logic [31:0] h,
                                              input logic [31:0] bpp);
    return (w * h * bpp) >> 3;
  endfunction

endpackage

// File: rtl/frame_setup_bufsel.sv
module frame_setup_bufsel #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_first,
  input  logic              go_idle,
  input  logic              flip,
  input  logic              dual,
  input  logic [ADDR_W-1:0] top0,
  input  logic [ADDR_W-1:0] bot0,
  input  logic [ADDR_W-1:0] top1,
  input  logic [ADDR_W-1:0] bot1,
  input  logic [3:0]        addr_ok,
  output logic              addr_bad,
  output logic              cur_buf,
  output logic              buf_idle,
  output logic [ADDR_W-1:0] cur_top,
  output logic [ADDR_W-1:0] cur_bot
);
  localparam int NBUF = 2;

  logic [ADDR_W-1:0] tops [NBUF];
  logic [ADDR_W-1:0] bots [NBUF];
  logic [NBUF-1:0]   pair_ok;
  logic [NBUF-1:0]   pair_used;

  assign tops[0] = top0;
  assign tops[1] = top1;
  assign bots[0] = bot0;
  assign bots[1] = bot1;

  for (genvar b = 0; b < NBUF; b++) begin : g_pair
    assign pair_ok[b]   = addr_ok[2*b] & addr_ok[2*b+1];
    assign pair_used[b] = (b == 0) ? 1'b1 : dual;
  end

  assign addr_bad = |(pair_used & ~pair_ok);
  assign cur_top  = tops[cur_buf];
  assign cur_bot  = bots[cur_buf];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_buf  <= 1'b0;
      buf_idle <= 1'b1;
    end else if (go_idle) begin
      cur_buf  <= 1'b0;
      buf_idle <= 1'b1;
    end else if (go_first) begin
      cur_buf  <= 1'b0;
      buf_idle <= 1'b0;
    end else if (flip && dual) begin
      cur_buf  <= ~cur_buf;
    end
  end
endmodule

// File: rtl/frame_setup_hdr_rd.sv
module frame_setup_hdr_rd #(
  parameter int ADDR_W    = 24,
  parameter int HDR_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         kill,
  input  logic [ADDR_W-1:0]            base,
  output logic                         mem_req,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_ack,
  input  logic [15:0]                  mem_rdata,
  output logic                         pal_we,
  output logic [$clog2(HDR_WORDS)-1:0] pal_idx,
  output logic [15:0]                  pal_wdata,
  output logic                         done,
  output logic [15:0]                  word0
);
  localparam int IDX_W = $clog2(HDR_WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(HDR_WORDS - 1);

  logic             busy;
  logic [IDX_W-1:0] cnt;
  logic             beat;

  assign mem_req   = busy;
  assign beat      = busy & mem_ack;
  assign pal_we    = beat;
  assign pal_idx   = cnt;
  assign pal_wdata = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      mem_addr <= '0;
      done     <= 1'b0;
      word0    <= '0;
    end else begin
      done <= 1'b0;
      if (kill) begin
        busy <= 1'b0;
      end else if (start && !busy) begin
        busy     <= 1'b1;
        cnt      <= '0;
        mem_addr <= base;
      end else if (beat) begin
        if (cnt == '0) word0 <= mem_rdata;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt      <= cnt + 1'b1;
          mem_addr <= mem_addr + ADDR_W'(2);
        end
      end
    end
  end
endmodule

// File: rtl/frame_setup_calc.sv
module frame_setup_calc
  import frame_setup_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LINE_W = 10
) (
  input  logic [15:0]         word0,
  input  logic                data_only,
  input  logic [LINE_W-1:0]   w_m1,
  input  logic [LINE_W-1:0]   h_m1,
  input  logic                sub_ovr,
  input  logic                sub_start,
  input  logic [LINE_W-1:0]   sub_val,
  input  logic [ADDR_W-1:0]   top,
  input  logic [ADDR_W-1:0]   bot,
  output logic [4:0]          bpp,
  output logic                zero_depth,
  output logic                fits,
  output logic [ADDR_W-1:0]   base,
  output logic [LINE_W+1:0]   stride,
  output logic [LINE_W:0]     lines,
  output logic [LINE_W-1:0]   first
);
  localparam int EW = ADDR_W + 2;

  logic [2:0]      code;
  logic [LINE_W:0] w_full, h_full;
  logic [31:0]     skip, need;
  logic [EW-1:0]   room;

  assign code       = word0[14:12];
  assign bpp        = depth_bits(code);
  assign zero_depth = (bpp == 5'd0);
  assign skip       = data_skip(code, data_only);
  assign w_full     = {1'b0, w_m1} + 1'b1;
  assign h_full     = {1'b0, h_m1} + 1'b1;
  assign need       = skip + frame_bytes(32'(w_full), 32'(h_full), 32'(bpp));
  assign room       = {2'b00, bot} - {2'b00, top} + EW'(FIT_SLACK);
  assign fits       = !room[EW-1] && (64'(need) <= 64'(room[EW-2:0]));
  assign base       = top + ADDR_W'(skip);
  assign stride     = (LINE_W+2)'(line_stride(32'(w_full), 32'(bpp)));
  assign lines      = (sub_ovr && !sub_start) ? {1'b0, sub_val} : h_full;
  assign first      = (sub_ovr && sub_start) ? sub_val : '0;
endmodule

// File: rtl/frame_setup_seq.sv
module frame_setup_seq
  import frame_setup_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LINE_W    = 10,
  parameter int HDR_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_enable,
  input  logic [1:0]                   cfg_hdr_mode,
  input  logic                         cfg_dual,
  input  logic [LINE_W-1:0]            cfg_width_m1,
  input  logic [LINE_W-1:0]            cfg_height_m1,
  input  logic                         cfg_sub_ovr,
  input  logic                         cfg_sub_start,
  input  logic [LINE_W-1:0]            cfg_sub_val,
  input  logic [1:0]                   cfg_irq_mask,
  input  logic [1:0]                   cfg_dma_ie,
  input  logic [ADDR_W-1:0]            buf0_top,
  input  logic [ADDR_W-1:0]            buf0_bot,
  input  logic [ADDR_W-1:0]            buf1_top,
  input  logic [ADDR_W-1:0]            buf1_bot,
  input  logic [3:0]                   addr_ok,
  input  logic                         frame_start,
  output logic                         mem_req,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_ack,
  input  logic [15:0]                  mem_rdata,
  output logic                         pal_we,
  output logic [$clog2(HDR_WORDS)-1:0] pal_idx,
  output logic [15:0]                  pal_wdata,
  output logic                         fetch_valid,
  output logic [ADDR_W-1:0]            fetch_base,
  output logic [LINE_W+1:0]            fetch_stride,
  output logic [LINE_W:0]              fetch_lines,
  output logic [LINE_W-1:0]            fetch_first,
  output logic [4:0]                   fetch_bpp,
  output logic                         frame_abort,
  output logic [2:0]                   cond_set,
  output logic                         dma_irq,
  output logic                         enable_clr,
  output logic                         lcd_irq,
  output logic                         stat_sync_err,
  output logic                         stat_pal_done,
  output logic                         stat_frame_done,
  output logic                         cur_buf,
  output logic                         buf_idle
);
  seq_st_t           st;
  logic              en_q;
  logic              data_only;
  logic [15:0]       word0;
  logic              rd_start, rd_done;
  logic              addr_bad;
  logic [ADDR_W-1:0] cur_top, cur_bot;
  logic [4:0]        c_bpp;
  logic              c_zero, c_fits;
  logic [ADDR_W-1:0] c_base;
  logic [LINE_W+1:0] c_stride;
  logic [LINE_W:0]   c_lines;
  logic [LINE_W-1:0] c_first;

  // named internal events
  logic ev_enable_rise, ev_disable, ev_bad_addr, ev_eval, ev_good, ev_overrun, ev_abort;

  assign data_only      = (cfg_hdr_mode == 2'd2);
  assign ev_enable_rise = cfg_enable && (st == ST_OFF);
  assign ev_disable     = en_q && !cfg_enable;
  assign ev_bad_addr    = cfg_enable && (st == ST_CHK) && addr_bad;
  assign ev_eval        = cfg_enable && (st == ST_EVAL);
  assign ev_abort       = ev_eval && c_zero;
  assign ev_good        = ev_eval && !c_zero && c_fits;
  assign ev_overrun     = ev_eval && !c_zero && !c_fits;
  assign rd_start       = cfg_enable && !data_only &&
                          (((st == ST_CHK) && !addr_bad && !stat_pal_done) ||
                           ((st == ST_RDY) && frame_start));

  frame_setup_bufsel #(.ADDR_W(ADDR_W)) u_bufsel (
    .clk(clk), .rst_n(rst_n), .go_first(ev_enable_rise), .go_idle(ev_disable),
    .flip(ev_good), .dual(cfg_dual), .top0(buf0_top), .bot0(buf0_bot),
    .top1(buf1_top), .bot1(buf1_bot), .addr_ok(addr_ok), .addr_bad(addr_bad),
    .cur_buf(cur_buf), .buf_idle(buf_idle), .cur_top(cur_top), .cur_bot(cur_bot)
  );

  frame_setup_hdr_rd #(.ADDR_W(ADDR_W), .HDR_WORDS(HDR_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .kill(!cfg_enable), .base(cur_top),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_wdata(pal_wdata),
    .done(rd_done), .word0(word0)
  );

  frame_setup_calc #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_calc (
    .word0(word0), .data_only(data_only), .w_m1(cfg_width_m1), .h_m1(cfg_height_m1),
    .sub_ovr(cfg_sub_ovr), .sub_start(cfg_sub_start), .sub_val(cfg_sub_val),
    .top(cur_top), .bot(cur_bot), .bpp(c_bpp), .zero_depth(c_zero), .fits(c_fits),
    .base(c_base), .stride(c_stride), .lines(c_lines), .first(c_first)
  );

  assign lcd_irq = (stat_frame_done & cfg_irq_mask[0]) |
                   (stat_pal_done & cfg_irq_mask[1]) | stat_sync_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= ST_OFF;
      en_q            <= 1'b0;
      fetch_valid     <= 1'b0;
      fetch_base      <= '0;
      fetch_stride    <= '0;
      fetch_lines     <= '0;
      fetch_first     <= '0;
      fetch_bpp       <= '0;
      frame_abort     <= 1'b0;
      cond_set        <= '0;
      dma_irq         <= 1'b0;
      enable_clr      <= 1'b0;
      stat_sync_err   <= 1'b0;
      stat_pal_done   <= 1'b0;
      stat_frame_done <= 1'b0;
    end else begin
      en_q        <= cfg_enable;
      fetch_valid <= 1'b0;
      frame_abort <= 1'b0;
      cond_set    <= '0;
      dma_irq     <= 1'b0;
      enable_clr  <= 1'b0;
      if (!cfg_enable) begin
        st <= ST_OFF;
        if (ev_disable) begin
          stat_sync_err <= 1'b0;
          if (cfg_hdr_mode != 2'd1) stat_frame_done <= 1'b1;
        end
      end else begin
        case (st)
          ST_OFF: begin
            st              <= ST_CHK;
            stat_pal_done   <= 1'b0;
            stat_frame_done <= 1'b0;
          end
          ST_CHK: begin
            if (ev_bad_addr) begin
              cond_set[2] <= 1'b1;
              dma_irq     <= cfg_dma_ie[1];
              enable_clr  <= 1'b1;
              st          <= ST_HALT;
            end else if (rd_start) st <= ST_LOAD;
            else                   st <= ST_RDY;
          end
          ST_LOAD: if (rd_done) begin
            stat_pal_done <= 1'b1;
            st            <= ST_RDY;
          end
          ST_RDY: if (frame_start) st <= data_only ? ST_EVAL : ST_HDR;
          ST_HDR: if (rd_done) st <= ST_EVAL;
          ST_EVAL: begin
            st <= ST_RDY;
            if (ev_abort) frame_abort <= 1'b1;
            else if (ev_overrun) begin
              stat_sync_err <= 1'b1;
              enable_clr    <= 1'b1;
              st            <= ST_HALT;
            end else begin
              fetch_valid       <= 1'b1;
              fetch_base        <= c_base;
              fetch_stride      <= c_stride;
              fetch_lines       <= c_lines;
              fetch_first       <= c_first;
              fetch_bpp         <= c_bpp;
              cond_set[cur_buf] <= 1'b1;
              dma_irq           <= cfg_dma_ie[0];
            end
          end
          default: st <= ST_HALT;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_setup_chk.sv
module frame_setup_chk #(
  parameter int ADDR_W    = 24,
  parameter int HDR_WORDS = 256
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_enable,
  input logic                         cfg_dual,
  input logic                         fetch_valid,
  input logic                         frame_abort,
  input logic [2:0]                   cond_set,
  input logic                         enable_clr,
  input logic                         stat_sync_err,
  input logic                         buf_idle,
  input logic                         cur_buf,
  input logic                         mem_req,
  input logic                         mem_ack,
  input logic [ADDR_W-1:0]            mem_addr,
  input logic [$clog2(HDR_WORDS)-1:0] pal_idx
);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && pal_idx != '1) |=> mem_addr == $past(mem_addr) + ADDR_W'(2));

  p_no_abort_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && frame_abort));

  p_err_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_sync_err) |-> enable_clr && !fetch_valid);

  p_bad_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cond_set[2] |-> enable_clr && !fetch_valid);

  p_cond_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_set));

  p_cond_buf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> cond_set[1:0] == ($past(cur_buf) ? 2'b10 : 2'b01));

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(cfg_dual)) |-> cur_buf != $past(cur_buf));

  p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_enable) |=> buf_idle && !stat_sync_err);
endmodule

bind frame_setup_seq frame_setup_chk #(.ADDR_W(ADDR_W), .HDR_WORDS(HDR_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dual(cfg_dual),
  .fetch_valid(fetch_valid), .frame_abort(frame_abort), .cond_set(cond_set),
  .enable_clr(enable_clr), .stat_sync_err(stat_sync_err), .buf_idle(buf_idle),
  .cur_buf(cur_buf), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .pal_idx(pal_idx)
);

// File: tb/frame_setup_seq_bench.sv
module frame_setup_seq_bench;
  localparam int AW = 24;
  localparam int LW = 10;
  localparam int NW = 256;
  localparam logic [AW-1:0] TOP0 = 24'h010000;
  localparam logic [AW-1:0] TOP1 = 24'h020000;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cfg_enable = 0, cfg_dual = 0, cfg_sub_ovr = 0, cfg_sub_start = 0, frame_start = 0;
  logic [1:0] cfg_hdr_mode = 0, cfg_irq_mask = 0, cfg_dma_ie = 0;
  logic [LW-1:0] cfg_width_m1 = 10'd63, cfg_height_m1 = 10'd31, cfg_sub_val = 0;
  logic [AW-1:0] buf0_top = TOP0, buf0_bot = TOP0 + 24'h4000;
  logic [AW-1:0] buf1_top = TOP1, buf1_bot = TOP1 + 24'h4000;
  logic [3:0] addr_ok = 4'hF;
  logic mem_req, mem_ack = 0, pal_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = 0, pal_wdata;
  logic [7:0] pal_idx;
  logic fetch_valid, frame_abort, dma_irq, enable_clr, lcd_irq;
  logic [AW-1:0] fetch_base;
  logic [LW+1:0] fetch_stride;
  logic [LW:0] fetch_lines;
  logic [LW-1:0] fetch_first;
  logic [4:0] fetch_bpp;
  logic [2:0] cond_set;
  logic stat_sync_err, stat_pal_done, stat_frame_done, cur_buf, buf_idle;

  frame_setup_seq u_frame_setup_seq (.*);

  int n_chk = 0, n_bad = 0;
  logic [2:0] code_b0 = 3, code_b1 = 1;

  function automatic logic [15:0] mdata(input logic [AW-1:0] a);
    if (a == TOP0) return {1'b0, code_b0, 12'h3c5};
    if (a == TOP1) return {1'b0, code_b1, 12'h0a1};
    return a[15:0] ^ 16'hA5A5;
  endfunction

  // memory: ack every other cycle while requested
  always @(posedge clk) begin
    #1;
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mdata(mem_addr);
  end

  // capture of pulses and header beats
  int rd_words = 0, seq_err = 0;
  logic got_fetch, got_abort, got_clr, got_dma;
  logic [2:0] cond_acc;
  logic [AW-1:0] cap_base, rd_base;
  logic [LW+1:0] cap_stride;
  logic [LW:0] cap_lines;
  logic [LW-1:0] cap_first;
  logic [4:0] cap_bpp;
  always @(negedge clk) begin
    if (pal_we) begin
      if (pal_idx != rd_words[7:0] || mem_addr != rd_base + AW'(2*rd_words) ||
          pal_wdata != mdata(mem_addr)) seq_err++;
      rd_words++;
    end
    if (fetch_valid) begin
      got_fetch = 1; cap_base = fetch_base; cap_stride = fetch_stride;
      cap_lines = fetch_lines; cap_first = fetch_first; cap_bpp = fetch_bpp;
    end
    if (frame_abort) got_abort = 1;
    if (enable_clr) got_clr = 1;
    if (dma_irq) got_dma = 1;
    cond_acc = cond_acc | cond_set;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_caps(input logic [AW-1:0] base);
    got_fetch = 0; got_abort = 0; got_clr = 0; got_dma = 0; cond_acc = 0;
    rd_words = 0; seq_err = 0; rd_base = base;
  endtask

  task automatic wait_done(input bit want_pal);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (got_fetch || got_abort || got_clr || (want_pal && stat_pal_done)) break;
    end
    @(negedge clk);
  endtask

  task automatic do_enable(input logic [AW-1:0] base);
    clear_caps(base);
    @(negedge clk); cfg_enable = 1;
  endtask

  task automatic do_disable();
    @(negedge clk); cfg_enable = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_frame(input logic [AW-1:0] base);
    clear_caps(base);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    wait_done(0);
  endtask

  function automatic int e_bpp(input logic [2:0] c);
    return (c == 0) ? 0 : (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 8 : 16;
  endfunction
  function automatic int e_off(input logic [2:0] c, input bit donly);
    if (donly) return 0;
    return (c > 2) ? 'h200 : 'h20;
  endfunction

  task automatic t_reset();
    check("R12 mem_req", mem_req, 0);
    check("R12 fetch_valid", fetch_valid, 0);
    check("R12 status", {stat_sync_err, stat_pal_done, stat_frame_done, lcd_irq}, 0);
    check("R12 buf_idle", buf_idle, 1);
    check("R12 pulses", {cond_set, dma_irq, enable_clr, frame_abort}, 0);
  endtask

  task automatic t_bad_addr();
    cfg_dma_ie = 2'b10; addr_ok = 4'b1101;
    do_enable(TOP0); wait_done(0);
    check("R1 cond bit2", cond_acc, 3'b100);
    check("R1 dma_irq", got_dma, 1);
    check("R1 enable_clr", got_clr, 1);
    check("R1 no read", rd_words, 0);
    do_disable();
    cfg_dual = 1; addr_ok = 4'b0111;
    do_enable(TOP0); wait_done(0);
    check("R1 dual buf1 invalid", {got_clr, cond_acc}, {1'b1, 3'b100});
    do_disable();
    cfg_dual = 0;
  endtask

  task automatic t_load();
    addr_ok = 4'b0011; cfg_irq_mask = 2'b10; cfg_dma_ie = 2'b01;
    do_enable(TOP0); wait_done(1);
    check("R1 buf1 flags ignored single", got_clr, 0);
    check("R2 words read", rd_words, NW);
    check("R2 order/address/data", seq_err, 0);
    check("R2 pal_done", stat_pal_done, 1);
    check("R11 irq from pal_done", lcd_irq, 1);
    check("R10 frame_done cleared", stat_frame_done, 0);
  endtask

  task automatic t_frame(input logic [2:0] c);
    code_b0 = c;
    do_frame(TOP0);
    check("R3 header re-read", rd_words, NW);
    check("R4 bpp", cap_bpp, e_bpp(c));
    check("R5 base", cap_base, TOP0 + AW'(e_off(c, 0)));
    check("R7 stride", cap_stride, 64 * e_bpp(c) / 8);
    check("R7 lines/first", {cap_lines, cap_first}, {11'd32, 10'd0});
    check("R9 cond/dma", {cond_acc, got_dma}, {3'b001, 1'b1});
    check("R9 single buf stays", cur_buf, 0);
  endtask

  task automatic t_abort();
    code_b0 = 0;
    do_frame(TOP0);
    check("R4 abort pulse", got_abort, 1);
    check("R4 no fetch/cond", {got_fetch, cond_acc}, 0);
  endtask

  task automatic t_sub();
    code_b0 = 3; cfg_sub_ovr = 1; cfg_sub_start = 1; cfg_sub_val = 10'd5;
    do_frame(TOP0);
    check("R8 first line", {cap_lines, cap_first}, {11'd32, 10'd5});
    cfg_sub_start = 0; cfg_sub_val = 10'd7;
    do_frame(TOP0);
    check("R8 height override", {cap_lines, cap_first}, {11'd7, 10'd0});
    cfg_sub_ovr = 0;
  endtask

  task automatic t_fit();
    code_b0 = 5; cfg_irq_mask = 2'b01;
    buf0_bot = TOP0 + 24'h1200 - 24'd2;
    do_frame(TOP0);
    check("R6 equality passes", {got_fetch, got_clr}, 2'b10);
    buf0_bot = TOP0 + 24'h11FD;
    do_frame(TOP0);
    check("R6 overrun no fetch", {got_fetch, cond_acc}, 0);
    check("R6 sync_err/enable_clr", {stat_sync_err, got_clr}, 2'b11);
    check("R11 irq from sync_err", lcd_irq, 1);
    do_disable();
    check("R10 off state", {buf_idle, stat_sync_err, stat_frame_done}, 3'b101);
    check("R11 irq from frame_done", lcd_irq, 1);
    buf0_bot = TOP0 + 24'h4000;
  endtask

  task automatic t_dual();
    cfg_dual = 1; addr_ok = 4'hF; code_b0 = 3; code_b1 = 1;
    do_enable(TOP0); wait_done(1);
    check("R10 enable selects buf0", {buf_idle, cur_buf}, 0);
    do_frame(TOP0);
    check("R9 dual first", {cap_base, cond_acc, cur_buf}, {TOP0 + 24'h200, 3'b001, 1'b1});
    do_frame(TOP1);
    check("R9 dual second", {cap_base, cond_acc, cur_buf}, {TOP1 + 24'h20, 3'b010, 1'b0});
    check("R3 read from buf1", seq_err, 0);
    do_disable();
    cfg_dual = 0;
  endtask

  task automatic t_data_only();
    cfg_hdr_mode = 2;
    do_enable(TOP0);
    repeat (20) @(negedge clk);
    check("R2 no load in data-only", {rd_words[7:0], stat_pal_done}, 0);
    do_frame(TOP0);
    check("R3 no read data-only", rd_words, 0);
    check("R5 offset 0, last word0 code", {cap_base, cap_bpp}, {TOP0, 5'd2});
    cfg_hdr_mode = 1;
    do_disable();
    check("R10 mode1 no frame_done", {stat_frame_done, buf_idle}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bad_addr();
    t_load();
    t_frame(3);
    t_frame(1);
    t_frame(2);
    t_frame(6);
    t_abort();
    t_sub();
    t_fit();
    t_dual();
    t_data_only();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule